// File: doc/BRIEF.md
# Language card bank controller

This block steers CPU accesses to a 16 KB RAM card that can overlay the ROM in the top 12 KB of a 16-bit address space (0xD000 to 0xFFFF). Software changes the card's mode by touching sixteen switch addresses in the I/O page. The controller decodes those accesses and keeps four state bits: which 4 KB bank is seen at 0xD000, whether reads of the overlay go to RAM, whether writes go to RAM, and a pre-write latch. A separate input picks one of two independent sets of card RAM.

For every access the block reports, combinationally, where the access lands. A read of the overlay goes either to ROM or to a card RAM bank. A write of the overlay either lands in card RAM or is dropped. Reads and writes are enabled separately, so a program can run from ROM while it copies that ROM into RAM. Two status offsets in the I/O page read back the bank select and the RAM-read state in the top data bit.

Top module: `lang_card_ctl`

## Requirements
- R1: Only accesses with address 0xC080 to 0xC08F change the state. Address bit 2 is ignored, so 0xC084 to 0xC087 act like 0xC080 to 0xC083 and 0xC08C to 0xC08F act like 0xC088 to 0xC08B. Every other address leaves the state unchanged.
- R2: The low two bits of a switch address set the read source. 00 and 11 send overlay reads to card RAM. 01 and 10 send overlay reads to ROM.
- R3: A switch access with address bit 3 set selects bank 1. With bit 3 clear it selects bank 2.
- R4: Any access, read or write, to a switch address with bit 0 clear turns off RAM write and clears the pre-write latch.
- R5: A read of a switch address with bit 0 set copies the pre-write latch into RAM write and then sets the latch. Two such reads in a row are needed to enable writes.
- R6: A write to a switch address with bit 0 set clears the pre-write latch and leaves RAM write unchanged.
- R7: After reset, bank 1 is selected and RAM read, RAM write and the pre-write latch are all off.
- R8: `ram_bank[0]` is 1 only for an access in 0xD000–0xDFFF while bank 2 is selected. Accesses in 0xE000–0xFFFF always report 0 there, because that range is a single area.
- R9: An overlay read asserts `rom_sel` when RAM read is off and `ram_rd` when it is on. An overlay write asserts `ram_wr_en` only when RAM write is on. At most one of the three is high. All three are low for any address outside 0xD000–0xFFFF and whenever `acc_valid` is low.
- R10: `ram_bank[1]` equals `alt_set` for every overlay access and is 0 otherwise.
- R11: A read of 0xC011 returns data bit 7 set when bank 2 is selected. A read of 0xC012 returns bit 7 set when RAM read is on. All other data bits are zero and `stat_hit` is high only for these two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A CPU access is present this cycle |
| acc_we | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 16 | Access address |
| alt_set | input | 1 | Selects the second set of card RAM |
| rom_sel | output | 1 | Overlay read is served by ROM |
| ram_rd | output | 1 | Overlay read is served by card RAM |
| ram_wr_en | output | 1 | Overlay write lands in card RAM |
| ram_bank | output | 2 | {RAM set, D-range bank 2} for overlay accesses |
| stat_hit | output | 1 | Access is a status read |
| stat_data | output | 8 | Status read data |

## Verification
The state that is hardest to reach is write enable. It needs two back-to-back reads of an odd switch address, and any even switch access or odd switch write in between breaks the sequence. Uniform random addresses would almost never produce this. The random stimulus therefore draws most addresses from the sixteen switch locations with a bias toward reads, and directed sequences hit each way the arming can be broken, including a use of the mirrored addresses. Between switch accesses the bench sends overlay reads and writes, so the armed state is observed at the ports.

// File: rtl/lc_pkg.sv
package lc_pkg;

   typedef enum logic [1:0] {
      LC_RAM_RD   = 2'b00,
      LC_ROM_ARM  = 2'b01,
      LC_ROM_ONLY = 2'b10,
      LC_RAM_ARM  = 2'b11
   } lc_mode_e;

   typedef struct packed {
      logic bank2;
      logic rd_en;
      logic wr_en;
      logic pre;
   } lc_state_t;

   function automatic logic mode_reads_ram(lc_mode_e m);
      return (m == LC_RAM_RD) || (m == LC_RAM_ARM);
   endfunction

endpackage

// File: rtl/lc_sw_decode.sv
module lc_sw_decode
   import lc_pkg::*;
#(
   parameter int          ADDR_W  = 16,
   parameter logic [7:0]  IO_PAGE = 8'hC0,
   parameter logic [7:0]  SW_BASE = 8'h80
) (
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              sw_hit,
   output lc_mode_e          sw_mode,
   output logic              sw_bank2
);
   localparam int PAGE_LSB = ADDR_W - 8;

   logic mirror_bit_unused;
   assign mirror_bit_unused = acc_addr[2];

   assign sw_hit   = acc_valid
                   && (acc_addr[ADDR_W-1:PAGE_LSB] == IO_PAGE)
                   && (acc_addr[PAGE_LSB-1:4] == SW_BASE[7:4]);
   assign sw_mode  = lc_mode_e'(acc_addr[1:0]);
   assign sw_bank2 = ~acc_addr[3];
endmodule

// File: rtl/lc_bank_state.sv
module lc_bank_state
   import lc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sw_hit,
   input  logic      sw_write,
   input  lc_mode_e  sw_mode,
   input  logic      sw_bank2,
   output lc_state_t state_q
);
   lc_state_t state_d;
   logic      odd_sel;

   assign odd_sel = sw_mode[0];

   always_comb begin
      state_d = state_q;
      if (sw_hit) begin
         state_d.bank2 = sw_bank2;
         state_d.rd_en = mode_reads_ram(sw_mode);
         if (!odd_sel) begin
            state_d.wr_en = 1'b0;
            state_d.pre   = 1'b0;
         end else if (!sw_write) begin
            state_d.wr_en = state_q.pre;
            state_d.pre   = 1'b1;
         end else begin
            state_d.pre   = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/lc_region_map.sv
module lc_region_map
   import lc_pkg::*;
#(
   parameter logic [3:0] D_NIBBLE = 4'hD
) (
   input  logic       acc_valid,
   input  logic       acc_we,
   input  logic [3:0] addr_top,
   input  logic       alt_set,
   input  lc_state_t  state_q,
   output logic       rom_sel,
   output logic       ram_rd,
   output logic       ram_wr_en,
   output logic [1:0] ram_bank
);
   logic in_d, in_ef, in_card;

   assign in_d    = (addr_top == D_NIBBLE);
   assign in_ef   = (addr_top[3:1] == 3'b111);
   assign in_card = acc_valid && (in_d || in_ef);

   assign rom_sel   = in_card && !acc_we && !state_q.rd_en;
   assign ram_rd    = in_card && !acc_we &&  state_q.rd_en;
   assign ram_wr_en = in_card &&  acc_we &&  state_q.wr_en;
   assign ram_bank  = in_card ? {alt_set, in_d && state_q.bank2} : 2'b00;
endmodule

// File: rtl/lang_card_ctl.sv
module lang_card_ctl
   import lc_pkg::*;
#(
   parameter int         ADDR_W    = 16,
   parameter int         DATA_W    = 8,
   parameter logic [7:0] IO_PAGE   = 8'hC0,
   parameter logic [7:0] SW_BASE   = 8'h80,
   parameter logic [7:0] ST_BANK   = 8'h11,
   parameter logic [7:0] ST_RDRAM  = 8'h12,
   parameter bit         STATUS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              alt_set,
   output logic              rom_sel,
   output logic              ram_rd,
   output logic              ram_wr_en,
   output logic [1:0]        ram_bank,
   output logic              stat_hit,
   output logic [DATA_W-1:0] stat_data
);
   localparam int PAGE_LSB = ADDR_W - 8;
   localparam int FLAG_BIT = DATA_W - 1;

   generate
      if (ADDR_W != 16) begin : g_bad_addr
         $error("lang_card_ctl: ADDR_W must be 16");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("lang_card_ctl: DATA_W must be positive");
      end
   endgenerate

   logic      sw_hit, sw_bank2;
   lc_mode_e  sw_mode;
   lc_state_t state_q;

   lc_sw_decode #(.ADDR_W(ADDR_W), .IO_PAGE(IO_PAGE), .SW_BASE(SW_BASE)) u_dec (
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .sw_hit    (sw_hit),
      .sw_mode   (sw_mode),
      .sw_bank2  (sw_bank2)
   );

   lc_bank_state u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_hit   (sw_hit),
      .sw_write (acc_we),
      .sw_mode  (sw_mode),
      .sw_bank2 (sw_bank2),
      .state_q  (state_q)
   );

   lc_region_map u_map (
      .acc_valid (acc_valid),
      .acc_we    (acc_we),
      .addr_top  (acc_addr[ADDR_W-1:ADDR_W-4]),
      .alt_set   (alt_set),
      .state_q   (state_q),
      .rom_sel   (rom_sel),
      .ram_rd    (ram_rd),
      .ram_wr_en (ram_wr_en),
      .ram_bank  (ram_bank)
   );

   generate
      if (STATUS_EN) begin : g_status
         logic io_rd, hit_bank, hit_rd;
         assign io_rd    = acc_valid && !acc_we
                         && (acc_addr[ADDR_W-1:PAGE_LSB] == IO_PAGE);
         assign hit_bank = io_rd && (acc_addr[PAGE_LSB-1:0] == ST_BANK);
         assign hit_rd   = io_rd && (acc_addr[PAGE_LSB-1:0] == ST_RDRAM);
         assign stat_hit = hit_bank || hit_rd;
         always_comb begin
            stat_data = '0;
            stat_data[FLAG_BIT] = (hit_bank && state_q.bank2)
                               || (hit_rd && state_q.rd_en);
         end
      end else begin : g_no_status
         assign stat_hit  = 1'b0;
         assign stat_data = '0;
      end
   endgenerate
endmodule

// File: rtl/lc_ctl_checker.sv
module lc_ctl_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_valid,
   input logic        acc_we,
   input logic [15:0] acc_addr,
   input logic        rom_sel,
   input logic        ram_rd,
   input logic        ram_wr_en,
   input logic        st_bank2,
   input logic        st_rd,
   input logic        st_wr,
   input logic        st_pre
);
   logic sw;
   assign sw = acc_valid && (acc_addr[15:4] == 12'hC08);

   a_r7_reset_state: assert property (@(posedge clk)
      !rst_n |=> (!st_bank2 && !st_rd && !st_wr && !st_pre));

   a_r1_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
      !sw |=> $stable({st_bank2, st_rd, st_wr, st_pre}));

   a_r3_bank_pick: assert property (@(posedge clk) disable iff (!rst_n)
      sw |=> (st_bank2 == !$past(acc_addr[3])));

   a_r4_even_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (sw && !acc_addr[0]) |=> (!st_wr && !st_pre));

   a_r5_odd_read_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (sw && acc_addr[0] && !acc_we) |=> (st_pre && (st_wr == $past(st_pre))));

   a_r6_odd_write: assert property (@(posedge clk) disable iff (!rst_n)
      (sw && acc_addr[0] && acc_we) |=> (!st_pre && (st_wr == $past(st_wr))));

   a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_sel, ram_rd, ram_wr_en}));
endmodule

bind lang_card_ctl lc_ctl_checker chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_we    (acc_we),
   .acc_addr  (acc_addr),
   .rom_sel   (rom_sel),
   .ram_rd    (ram_rd),
   .ram_wr_en (ram_wr_en),
   .st_bank2  (state_q.bank2),
   .st_rd     (state_q.rd_en),
   .st_wr     (state_q.wr_en),
   .st_pre    (state_q.pre)
);

// File: tb/lang_card_ctl_tb_top.sv
`timescale 1ns/1ps
module lang_card_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_we = 1'b0;
   logic [15:0] acc_addr = 16'h0000;
   logic        alt_set = 1'b0;
   logic        rom_sel, ram_rd, ram_wr_en, stat_hit;
   logic [1:0]  ram_bank;
   logic [7:0]  stat_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   bit m_bank2, m_rd, m_wr, m_pre;

   always #2 clk = ~clk;

   lang_card_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
      .acc_addr(acc_addr), .alt_set(alt_set), .rom_sel(rom_sel),
      .ram_rd(ram_rd), .ram_wr_en(ram_wr_en), .ram_bank(ram_bank),
      .stat_hit(stat_hit), .stat_data(stat_data)
   );

   function automatic logic [13:0] expect_out(input logic v, input logic we,
                                              input logic [15:0] a, input logic alt);
      logic in_d, card, sh;
      logic [7:0] sd;
      in_d = (a[15:12] == 4'hD);
      card = v && (in_d || (a[15:13] == 3'b111));
      sh   = v && !we && ((a == 16'hC011) || (a == 16'hC012));
      sd   = 8'h00;
      if (sh && a == 16'hC011) sd[7] = m_bank2;
      if (sh && a == 16'hC012) sd[7] = m_rd;
      return {card && !we && !m_rd, card && !we && m_rd, card && we && m_wr,
              card ? {alt, in_d && m_bank2} : 2'b00, sh, sd};
   endfunction

   task automatic model_step(input logic v, input logic we, input logic [15:0] a);
      if (v && a[15:4] == 12'hC08) begin
         m_bank2 = !a[3];
         m_rd    = (a[1:0] == 2'b00) || (a[1:0] == 2'b11);
         if (!a[0]) begin m_wr = 0; m_pre = 0; end
         else if (!we) begin m_wr = m_pre; m_pre = 1; end
         else m_pre = 0;
      end
   endtask

   task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%h act=%h exp=%h", tag, acc_addr, act, exp);
      end
   endtask

   task automatic access(input string tag, input logic v, input logic we,
                         input logic [15:0] a, input logic alt);
      @(negedge clk);
      acc_valid = v; acc_we = we; acc_addr = a; alt_set = alt;
      #1;
      check(tag, {rom_sel, ram_rd, ram_wr_en, ram_bank, stat_hit, stat_data},
            expect_out(v, we, a, alt));
      model_step(v, we, a);
   endtask

   function automatic logic [15:0] pick_addr();
      int r;
      r = $urandom_range(0, 99);
      if (r < 45) return {12'hC08, 4'($urandom_range(0, 15))};
      if (r < 55) return $urandom_range(0, 1) ? 16'hC011 : 16'hC012;
      if (r < 90) return 16'hD000 + 16'($urandom_range(0, 16'h2FFF));
      return 16'($urandom());
   endfunction

   initial begin
      void'($urandom(32'd1234));
      m_bank2 = 0; m_rd = 0; m_wr = 0; m_pre = 0;
      repeat (3) @(posedge clk);
      // R7: reset state seen at ports
      access("R7 reset rom read", 1, 0, 16'hE123, 0);
      access("R7 reset write dropped", 1, 1, 16'hD010, 0);
      access("R7 R11 reset bank status", 1, 0, 16'hC011, 0);
      rst_n = 1'b1;
      // R5: one odd read does not enable writes; two do
      access("R5 arm1", 1, 0, 16'hC08B, 0);
      access("R5 single read no write", 1, 1, 16'hE000, 0);
      access("R5 arm2", 1, 0, 16'hC08B, 0);
      access("R5 R2 ram write enabled", 1, 1, 16'hE000, 0);
      access("R2 R8 ram read bank1", 1, 0, 16'hD456, 0);
      // R4: even access clears
      access("R4 even write", 1, 1, 16'hC088, 0);
      access("R4 write disabled", 1, 1, 16'hF000, 0);
      // R6: odd write breaks arming and keeps wr
      access("R6 odd read", 1, 0, 16'hC081, 0);
      access("R6 odd write", 1, 1, 16'hC081, 0);
      access("R6 odd read again", 1, 0, 16'hC081, 0);
      access("R6 R9 still no write, rom read", 1, 1, 16'hD000, 0);
      access("R9 rom read while armed", 1, 0, 16'hD000, 0);
      access("R6 second read arms", 1, 0, 16'hC081, 0);
      access("R9 write ram while rom read", 1, 1, 16'hDFFF, 0);
      access("R6 odd write keeps wr", 1, 1, 16'hC085, 0);
      access("R6 wr unchanged", 1, 1, 16'hDFFF, 1);
      // R1: mirror and non-switch addresses
      access("R1 mirror bank1 rdwr", 1, 0, 16'hC08F, 1);
      access("R1 R8 bank1 D range", 1, 0, 16'hD800, 1);
      access("R1 R3 mirror bank2", 1, 0, 16'hC084, 1);
      access("R8 R10 bank2 D alt", 1, 0, 16'hD800, 1);
      access("R8 EF single area", 1, 0, 16'hFFFF, 1);
      access("R11 bank2 status", 1, 0, 16'hC011, 0);
      access("R11 ramrd status", 1, 0, 16'hC012, 0);
      access("R1 near miss", 1, 0, 16'hC090, 0);
      access("R1 near miss 2", 1, 0, 16'hC180, 0);
      access("R1 state kept", 1, 0, 16'hC011, 0);
      access("R9 idle no valid", 0, 0, 16'hD000, 1);
      access("R1 invalid switch ignored", 0, 0, 16'hC08A, 0);
      access("R1 state after invalid", 1, 0, 16'hC012, 0);
      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] a;
         a = pick_addr();
         access("R1/R2/R3/R4/R5/R6/R8/R9/R10/R11 random",
                ($urandom_range(0, 9) != 0),
                ($urandom_range(0, 3) == 0), a, 1'($urandom_range(0, 1)));
      end
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule